// File: doc/BRIEF.md
# In-System Programming Stage Sequencer

This block steps a nonvolatile programmable device through its in-system programming flow. A start pulse launches a run. A mode input chooses the kind of run. A full run erases the device, programs every address from a pattern memory, verifies every address, and then leaves programming mode. A verify-only run reads the device back and compares it against the pattern, without erasing or writing.

All traffic to the device goes through a serial shift engine, which sits outside this block. For each instruction, address or data transfer, the sequencer raises a request with an operation code and waits for a one-cycle acknowledge. The shift engine returns read-back data with the acknowledge. After a transfer is acknowledged, the fixed-length pulses (stage entry, stage exit, erase, program and read) are timed by an internal cycle counter and shown on `pulse_on`.

While a run is active, the sequencer holds the user I/O in tri-state. When the run ends it reports done, pass or fail, an error code, and the first address that failed.

Top module: `isp_flow_seq`

## Requirements
- R1: A full run (`verify_only`=0) issues shift operations in this order: ENTER(0), READ_ID(1), ERASE(2), then PROGRAM(3) for each address from 0 upward, then READ_ADDR(4) and READ_OUT(5) for each address from 0 upward, then EXIT(6). The codes are the values on `sh_op`.
- R2: A verify-only run (`verify_only`=1, sampled at start) issues ENTER, READ_ID, READ_ADDR/READ_OUT for each address, and EXIT. It issues no ERASE and no PROGRAM.
- R3: After ENTER is acknowledged, `pulse_on` stays high for STAGE_MS*CYC_PER_MS cycles. The same holds after EXIT is acknowledged. Every run, including a failing one, ends with the EXIT stage before `done` rises.
- R4: After ERASE is acknowledged, `pulse_on` stays high for ERASE_MS*CYC_PER_MS cycles.
- R5: Each PROGRAM transfer presents `sh_addr` together with the pattern word for that address on `sh_wdata`, and is followed by a PGM_PULSE-cycle pulse. After a full run, the device holds the pattern.
- R6: Each READ_ADDR transfer is followed by an RD_PULSE-cycle pulse. The low DATA_W bits of `sh_rdata`, returned with the READ_OUT acknowledge, are compared with the pattern word for that address.
- R7: If the ID returned with the READ_ID acknowledge differs from `expected_id`, the run goes straight to EXIT, and `fail`=1 with `err_code`=1.
- R8: A verify mismatch sets `fail`=1 and `err_code`=2. `fail_addr` holds the lowest mismatching address. All remaining addresses are still read before EXIT.
- R9: `io_tristate` rises in the cycle after an accepted start. It stays high through the whole run, including every transfer and pulse, and falls in the same cycle that `done` rises.
- R10: `sh_req` stays high with a stable `sh_op` until `sh_ack` arrives. `pulse_on` is never high while `sh_req` is high, and a pulse begins the cycle after its acknowledge.
- R11: After reset, `done`, `fail`, `busy`, `io_tristate`, `sh_req` and `pulse_on` are 0 and `err_code` is 0.
- R12: A start pulse during a run has no effect. The next accepted start clears `done`, `fail`, `err_code` and `fail_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| verify_only | input | 1 | 1 selects a verify-only run |
| expected_id | input | ID_W | Silicon ID the device must report |
| sh_req | output | 1 | Shift transfer request |
| sh_op | output | 3 | Operation code of the transfer |
| sh_addr | output | ADDR_W | Address for PROGRAM / READ_ADDR |
| sh_wdata | output | DATA_W | Data for PROGRAM |
| sh_ack | input | 1 | One-cycle transfer acknowledge |
| sh_rdata | input | RD_W | Read-back data, valid with `sh_ack` |
| pat_addr | output | ADDR_W | Pattern memory address |
| pat_data | input | DATA_W | Pattern word, combinational from `pat_addr` |
| pulse_on | output | 1 | Timed pulse in progress |
| io_tristate | output | 1 | User I/O held tri-stated with pull-ups |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Run failed |
| err_code | output | 2 | 0 none, 1 ID mismatch, 2 verify mismatch |
| fail_addr | output | ADDR_W | First mismatching address |

## Verification
The bench builds the block with CYC_PER_MS=20, ERASE_MS=100, STAGE_MS=1, PGM_PULSE=5, RD_PULSE=3, NUM_ADDR=8 and DATA_W=8. With these values the 100 ms erase becomes 2000 cycles and each full run about 2300 cycles. That makes it possible to run many flows in one run: full and verify-only runs, an ID abort, corruption at the first, last and random addresses, and a start issued mid-run. In each run the bench checks every operation code and the length of every pulse against sequences it computes itself.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;

  typedef enum logic [2:0] {
    OP_ENTER     = 3'd0,
    OP_READ_ID   = 3'd1,
    OP_ERASE     = 3'd2,
    OP_PROGRAM   = 3'd3,
    OP_READ_ADDR = 3'd4,
    OP_READ_OUT  = 3'd5,
    OP_EXIT      = 3'd6
  } isp_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ENTER_SH, ST_ENTER_WT,
    ST_ID_SH,
    ST_ERASE_SH, ST_ERASE_WT,
    ST_PGM_SH,   ST_PGM_WT,
    ST_VFY_SH,   ST_VFY_WT, ST_VFY_RD,
    ST_EXIT_SH,  ST_EXIT_WT
  } isp_state_e;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_ID     = 2'd1;
  localparam logic [1:0] ERR_VERIFY = 2'd2;

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ms_to_cycles(int ms, int cyc_per_ms);
    return ms * cyc_per_ms;
  endfunction

  function automatic logic is_shift(isp_state_e s);
    return s inside {ST_ENTER_SH, ST_ID_SH, ST_ERASE_SH, ST_PGM_SH,
                     ST_VFY_SH, ST_VFY_RD, ST_EXIT_SH};
  endfunction

  function automatic isp_op_e state_op(isp_state_e s);
    case (s)
      ST_ID_SH:    return OP_READ_ID;
      ST_ERASE_SH: return OP_ERASE;
      ST_PGM_SH:   return OP_PROGRAM;
      ST_VFY_SH:   return OP_READ_ADDR;
      ST_VFY_RD:   return OP_READ_OUT;
      ST_EXIT_SH:  return OP_EXIT;
      default:     return OP_ENTER;
    endcase
  endfunction

endpackage

// File: rtl/isp_pulse_timer.sv
module isp_pulse_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             active,
  output logic             fire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
  assign fire   = (cnt == CNT_W'(1));

  // a new pulse is only ever launched on an idle timer
  assert_load_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);

  // the final pulse cycle is followed by an idle timer
  assert_pulse_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !active);

endmodule

// File: rtl/isp_addr_walker.sv
module isp_addr_walker #(
  parameter int NUM_ADDR = 256,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (clear)  addr <= '0;
    else if (step)   addr <= addr + 1'b1;
  end

  assign last = (addr == ADDR_W'(NUM_ADDR - 1));

  // the walk never runs past the top address
  assert_no_step_past_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !last);

  assert_clear_step_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && step));

endmodule

// File: rtl/isp_flow_seq.sv
module isp_flow_seq
  import isp_seq_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int STAGE_MS   = 1,
  parameter int ERASE_MS   = 100,
  parameter int PGM_PULSE  = 500,
  parameter int RD_PULSE   = 50,
  parameter int NUM_ADDR   = 256,
  parameter int DATA_W     = 16,
  parameter int ID_W       = 32,
  localparam int ADDR_W    = $clog2(NUM_ADDR),
  localparam int RD_W      = (ID_W > DATA_W) ? ID_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              verify_only,
  input  logic [ID_W-1:0]   expected_id,
  output logic              sh_req,
  output logic [2:0]        sh_op,
  output logic [ADDR_W-1:0] sh_addr,
  output logic [DATA_W-1:0] sh_wdata,
  input  logic              sh_ack,
  input  logic [RD_W-1:0]   sh_rdata,
  output logic [ADDR_W-1:0] pat_addr,
  input  logic [DATA_W-1:0] pat_data,
  output logic              pulse_on,
  output logic              io_tristate,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [1:0]        err_code,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int STAGE_CYC = ms_to_cycles(STAGE_MS, CYC_PER_MS);
  localparam int ERASE_CYC = ms_to_cycles(ERASE_MS, CYC_PER_MS);
  localparam int MAX_CYC   = max_of(max_of(STAGE_CYC, ERASE_CYC),
                                    max_of(PGM_PULSE, RD_PULSE));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  isp_state_e        state, nxt;
  logic              mode_vfy;
  logic              tmr_load, tmr_fire;
  logic [CNT_W-1:0]  tmr_len;
  logic              a_clr, a_step, a_last;
  logic [ADDR_W-1:0] addr;

  // named internal events
  logic go, shift_ack, id_bad, vfy_miss, run_end;

  assign go        = start && (state == ST_IDLE);
  assign shift_ack = sh_req && sh_ack;
  assign id_bad    = shift_ack && (state == ST_ID_SH) &&
                     (sh_rdata[ID_W-1:0] != expected_id);
  assign vfy_miss  = shift_ack && (state == ST_VFY_RD) &&
                     (sh_rdata[DATA_W-1:0] != pat_data);
  assign run_end   = (state == ST_EXIT_WT) && tmr_fire;

  isp_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len),
    .active(pulse_on), .fire(tmr_fire)
  );

  isp_addr_walker #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clear(a_clr), .step(a_step),
    .addr(addr), .last(a_last)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_len  = '0;
    a_clr    = 1'b0;
    a_step   = 1'b0;
    case (state)
      ST_IDLE:     if (start) begin nxt = ST_ENTER_SH; a_clr = 1'b1; end
      ST_ENTER_SH: if (sh_ack) begin
                     nxt = ST_ENTER_WT; tmr_load = 1'b1; tmr_len = CNT_W'(STAGE_CYC);
                   end
      ST_ENTER_WT: if (tmr_fire) nxt = ST_ID_SH;
      ST_ID_SH:    if (sh_ack) begin
                     if (id_bad)        nxt = ST_EXIT_SH;
                     else if (mode_vfy) nxt = ST_VFY_SH;
                     else               nxt = ST_ERASE_SH;
                   end
      ST_ERASE_SH: if (sh_ack) begin
                     nxt = ST_ERASE_WT; tmr_load = 1'b1; tmr_len = CNT_W'(ERASE_CYC);
                   end
      ST_ERASE_WT: if (tmr_fire) nxt = ST_PGM_SH;
      ST_PGM_SH:   if (sh_ack) begin
                     nxt = ST_PGM_WT; tmr_load = 1'b1; tmr_len = CNT_W'(PGM_PULSE);
                   end
      ST_PGM_WT:   if (tmr_fire) begin
                     if (a_last) begin nxt = ST_VFY_SH; a_clr = 1'b1; end
                     else        begin nxt = ST_PGM_SH; a_step = 1'b1; end
                   end
      ST_VFY_SH:   if (sh_ack) begin
                     nxt = ST_VFY_WT; tmr_load = 1'b1; tmr_len = CNT_W'(RD_PULSE);
                   end
      ST_VFY_WT:   if (tmr_fire) nxt = ST_VFY_RD;
      ST_VFY_RD:   if (sh_ack) begin
                     if (a_last) nxt = ST_EXIT_SH;
                     else begin nxt = ST_VFY_SH; a_step = 1'b1; end
                   end
      ST_EXIT_SH:  if (sh_ack) begin
                     nxt = ST_EXIT_WT; tmr_load = 1'b1; tmr_len = CNT_W'(STAGE_CYC);
                   end
      ST_EXIT_WT:  if (tmr_fire) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_vfy    <= 1'b0;
      io_tristate <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      err_code    <= ERR_NONE;
      fail_addr   <= '0;
    end else begin
      state <= nxt;
      if (go) begin
        mode_vfy    <= verify_only;
        io_tristate <= 1'b1;
        done        <= 1'b0;
        fail        <= 1'b0;
        err_code    <= ERR_NONE;
        fail_addr   <= '0;
      end
      if (id_bad) begin
        fail     <= 1'b1;
        err_code <= ERR_ID;
      end
      if (vfy_miss && !fail) begin
        fail      <= 1'b1;
        err_code  <= ERR_VERIFY;
        fail_addr <= addr;
      end
      if (run_end) begin
        io_tristate <= 1'b0;
        done        <= 1'b1;
      end
    end
  end

  assign sh_req   = is_shift(state);
  assign sh_op    = 3'(state_op(state));
  assign sh_addr  = addr;
  assign sh_wdata = pat_data;
  assign pat_addr = addr;
  assign busy     = (state != ST_IDLE);

  // ---------------- assertions ----------------
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req && !sh_ack |=> sh_req && $stable(sh_op));

  assert_no_pulse_in_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> !sh_req);

  assert_pulse_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ack && (state != ST_ID_SH) && (state != ST_VFY_RD) |=> pulse_on);

  assert_io_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_req || pulse_on) |-> io_tristate);

  assert_done_via_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state) == ST_EXIT_WT);

  assert_err_implies_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != ERR_NONE) |-> fail);

  assert_first_miss_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !go |=> $stable(fail_addr) && fail);

  assert_id_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_bad |=> state == ST_EXIT_SH);

endmodule

// File: tb/tb_isp_flow_seq.sv
module tb_isp_flow_seq;

  localparam int CPM = 20, SMS = 1, EMS = 100, PGMP = 5, RDP = 3;
  localparam int NA = 8, DW = 8, IW = 16, AW = 3, RW = 16;
  localparam logic [IW-1:0] GOOD_ID = 16'hC0DE;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, verify_only = 1'b0;
  logic [IW-1:0] expected_id = GOOD_ID;
  logic sh_req, sh_ack, pulse_on, io_tristate, busy, done, fail;
  logic [2:0] sh_op;
  logic [AW-1:0] sh_addr, pat_addr, fail_addr;
  logic [DW-1:0] sh_wdata, pat_data;
  logic [RW-1:0] sh_rdata;
  logic [1:0] err_code;

  logic [DW-1:0] pattern [NA];
  logic [DW-1:0] cells   [NA];
  logic [DW-1:0] corrupt [NA];
  logic [IW-1:0] dev_id = GOOD_ID;

  int oplog [64];  int opn = 0;
  int plog  [64];  int pn = 0;  int prun = 0;
  int exp_ops [64]; int exp_on;
  int exp_pl  [64]; int exp_pn;
  int n_chk = 0, n_fail = 0, tri_bad = 0;

  always #10 clk = ~clk;

  assign pat_data = pattern[pat_addr];

  isp_flow_seq #(
    .CYC_PER_MS(CPM), .STAGE_MS(SMS), .ERASE_MS(EMS), .PGM_PULSE(PGMP),
    .RD_PULSE(RDP), .NUM_ADDR(NA), .DATA_W(DW), .ID_W(IW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .verify_only(verify_only),
    .expected_id(expected_id), .sh_req(sh_req), .sh_op(sh_op),
    .sh_addr(sh_addr), .sh_wdata(sh_wdata), .sh_ack(sh_ack),
    .sh_rdata(sh_rdata), .pat_addr(pat_addr), .pat_data(pat_data),
    .pulse_on(pulse_on), .io_tristate(io_tristate), .busy(busy),
    .done(done), .fail(fail), .err_code(err_code), .fail_addr(fail_addr)
  );

  // behavioural shift engine + device cells
  initial begin
    int op, a, rd_a;
    logic [DW-1:0] w;
    sh_ack = 1'b0; sh_rdata = '0; rd_a = 0;
    forever begin
      @(negedge clk);
      if (sh_req === 1'b1) begin
        op = int'(sh_op); a = int'(sh_addr); w = sh_wdata;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        sh_rdata = '0;
        case (op)
          1: sh_rdata = RW'(dev_id);
          2: for (int i = 0; i < NA; i++) cells[i] = '1;
          3: cells[a] = w;
          4: rd_a = a;
          5: sh_rdata = RW'(cells[rd_a] ^ corrupt[rd_a]);
          default: ;
        endcase
        if (opn < 64) oplog[opn] = op;
        opn++;
        sh_ack = 1'b1;
        @(negedge clk);
        sh_ack = 1'b0;
      end
    end
  end

  // pulse-length and I/O monitor
  always @(negedge clk) begin
    if (rst_n && (sh_req || pulse_on) && !io_tristate) tri_bad++;
    if (pulse_on) prun++;
    else if (prun > 0) begin
      if (pn < 64) plog[pn] = prun;
      pn++;
      prun = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int first_bad();
    for (int i = 0; i < NA; i++) if (corrupt[i] != '0) return i;
    return -1;
  endfunction

  task automatic build_exp(input bit vo, input bit id_ok);
    exp_on = 0; exp_pn = 0;
    exp_ops[exp_on++] = 0; exp_pl[exp_pn++] = SMS * CPM;
    exp_ops[exp_on++] = 1;
    if (id_ok) begin
      if (!vo) begin
        exp_ops[exp_on++] = 2; exp_pl[exp_pn++] = EMS * CPM;
        for (int i = 0; i < NA; i++) begin
          exp_ops[exp_on++] = 3; exp_pl[exp_pn++] = PGMP;
        end
      end
      for (int i = 0; i < NA; i++) begin
        exp_ops[exp_on++] = 4; exp_pl[exp_pn++] = RDP;
        exp_ops[exp_on++] = 5;
      end
    end
    exp_ops[exp_on++] = 6; exp_pl[exp_pn++] = SMS * CPM;
  endtask

  task automatic run_flow(input bit vo, input bit id_ok, input bit extra_start,
                          input string rq);
    int t, fb, tb0;
    build_exp(vo, id_ok);
    opn = 0; pn = 0; prun = 0; tb0 = tri_bad;
    @(negedge clk); verify_only = vo; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(io_tristate == 1'b1 && done == 1'b0, "R9", "io_tristate after start",
        int'(io_tristate), 1);
    if (extra_start) begin
      repeat (60) @(negedge clk);
      verify_only = ~vo; start = 1'b1;
      @(negedge clk); start = 1'b0; verify_only = vo;
    end
    t = 0;
    while (done !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
    chk(done === 1'b1, rq, "done reached", int'(done), 1);
    chk(io_tristate == 1'b0 && busy == 1'b0, "R9", "io released at done",
        int'(io_tristate), 0);
    repeat (3) @(negedge clk);
    chk(opn == exp_on, extra_start ? "R12" : rq, "op count", opn, exp_on);
    for (int i = 0; i < exp_on && i < opn; i++)
      if (oplog[i] != exp_ops[i]) begin
        chk(1'b0, vo ? "R2" : "R1", "op code", oplog[i], exp_ops[i]);
        break;
      end
    chk(pn == exp_pn, "R10", "pulse count", pn, exp_pn);
    for (int i = 0; i < exp_pn && i < pn; i++)
      chk(plog[i] == exp_pl[i],
          (i == 0 || i == exp_pn - 1) ? "R3" :
          (exp_pl[i] == EMS * CPM) ? "R4" :
          (exp_pl[i] == PGMP) ? "R5" : "R6",
          "pulse length", plog[i], exp_pl[i]);
    chk(tri_bad == tb0, "R9", "io held during activity", tri_bad - tb0, 0);
    if (!id_ok) begin
      chk(fail && err_code == 2'd1, "R7", "ID abort flags", int'(err_code), 1);
    end else begin
      fb = first_bad();
      if (fb < 0) begin
        chk(!fail && err_code == 2'd0, rq, "pass flags", int'(err_code), 0);
      end else begin
        chk(fail && err_code == 2'd2, "R8", "verify fail code", int'(err_code), 2);
        chk(int'(fail_addr) == fb, "R8", "first fail addr", int'(fail_addr), fb);
      end
    end
  endtask

  task automatic new_pattern();
    for (int i = 0; i < NA; i++) pattern[i] = DW'($urandom_range(0, 255));
  endtask

  task automatic clear_corrupt();
    for (int i = 0; i < NA; i++) corrupt[i] = '0;
  endtask

  task automatic check_cells(input string rq);
    int bad = 0;
    for (int i = 0; i < NA; i++) if (cells[i] != pattern[i]) bad++;
    chk(bad == 0, rq, "device contents vs pattern", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NA; i++) cells[i] = 8'h5A;
    new_pattern();
    clear_corrupt();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!done && !fail && !busy && !io_tristate && !sh_req && !pulse_on &&
        err_code == 2'd0, "R11", "reset outputs",
        int'({done, fail, busy, io_tristate, sh_req, pulse_on}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // full program, clean
    run_flow(1'b0, 1'b1, 1'b0, "R1");
    check_cells("R5");

    // verify-only, clean
    run_flow(1'b1, 1'b1, 1'b0, "R2");

    // verify-only, misses at 5 and 2 -> first is 2, all still read
    corrupt[5] = 8'h10; corrupt[2] = 8'h01;
    run_flow(1'b1, 1'b1, 1'b0, "R8");
    clear_corrupt();

    // ID mismatch on full run: no erase, cells untouched
    dev_id = GOOD_ID ^ 16'h0100;
    run_flow(1'b0, 1'b0, 1'b0, "R7");
    check_cells("R7");
    dev_id = GOOD_ID;

    // new pattern, start pulsed mid-run; flags cleared from previous fail
    new_pattern();
    run_flow(1'b0, 1'b1, 1'b1, "R12");
    check_cells("R5");

    // boundary: only last / only first address corrupted
    corrupt[NA-1] = 8'h80;
    run_flow(1'b1, 1'b1, 1'b0, "R8");
    clear_corrupt();
    corrupt[0] = 8'hFF;
    run_flow(1'b1, 1'b1, 1'b0, "R8");
    clear_corrupt();

    // random mix
    for (int k = 0; k < 4; k++) begin
      bit vo;
      vo = 1'($urandom_range(0, 1));
      if (!vo) new_pattern();
      for (int i = 0; i < NA; i++)
        corrupt[i] = ($urandom_range(0, 3) == 0) ? DW'($urandom_range(1, 255)) : '0;
      run_flow(vo, 1'b1, 1'b0, vo ? "R6" : "R1");
      clear_corrupt();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule